// File: doc/BRIEF.md
# Integer Add Execution Unit with Arithmetic Flags

This block is the add execution slot of a micro-operation pipeline. Each accepted operation sums a first source register with either a second source register or a sign-extended immediate. The carry-consuming variants also add the current carry flag. The sum is taken at a selected width of 8, 16, 32 or 64 bits. The unit derives a full arithmetic flag set from that sum: duplicated carry and zero flags, parity, nibble carry, sign and signed overflow.

A per-operation 8-bit write mask picks which of these flags are written into the unit's flag register. The result and the updated flag register appear one clock after the operation is presented with `in_valid`. The carry flag held in that register feeds the next carry-consuming operation, so chains of wide additions can be issued back to back.

Top module: `add_exec_unit`

## Requirements
- R1: An operation presented with `in_valid` high produces `out_valid` high on the next clock edge, with `out_dest` = src1 + src2 truncated to the selected width for op code 0 (register add). `out_valid` is low after any cycle without `in_valid`.
- R2: Op code 1 (immediate add) replaces src2 with the 16-bit immediate, sign-extended to the selected width.
- R3: Op codes 2 (register) and 3 (immediate) also add bit 0 (carry) of the flag register as it stood before the operation. Bit 0 of the op code selects the immediate, and bit 1 selects carry-in.
- R4: The width code is 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. Only operand bits below the width take part, and `out_dest` bits at or above the width are zero.
- R5: Flag bits 0 and 1 both receive the carry out of the top bit of the selected width.
- R6: Flag bits 2 and 3 both receive 1 when the width-truncated result is zero.
- R7: Flag bit 4 receives 1 when the lowest result byte has an even number of ones.
- R8: Flag bit 5 receives the carry from bit 3 into bit 4 of the addition.
- R9: Flag bit 6 receives the top result bit at the selected width. Flag bit 7 receives 1 when both addends share a sign and the result sign differs; for carry forms the carry-in is part of the sum.
- R10: A flag bit is written only when the same bit of `in_fmask` is 1. Other bits keep their value, and nothing changes while `in_valid` is low.
- R11: Synchronous active-high reset clears `out_valid`, `out_dest` and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Op code: bit 0 immediate, bit 1 carry-in |
| in_width | input | 2 | Width code (8/16/32/64) |
| in_src1 | input | 64 | First source operand |
| in_src2 | input | 64 | Second source operand |
| in_imm | input | 16 | Immediate, sign-extended |
| in_fmask | input | 8 | Flag write mask |
| out_valid | output | 1 | Result valid |
| out_dest | output | 64 | Registered result |
| out_flags | output | 8 | Flag register contents |

## Verification
Vectors cover each op code at every width. Carry-out operands, such as 0xFF + 1 at 8 bits and two 64-bit negatives, separate carry, zero and overflow. The 0x7F + 1 case tells overflow apart from carry. Nibble-edge values separate the auxiliary carry from the main carry. Junk in the upper operand bits shows whether truncation happens before the add. Negative immediates show whether sign extension is applied. Carry-in chains follow an operation that set or cleared the carry flag, so a dropped or stale carry shows as an off-by-one result. Partial masks, idle cycles and a zero mask confirm that unselected flags survive.

// File: rtl/add_unit_pkg.sv
package add_unit_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_ADDI = 2'd1,
        OP_ADC  = 2'd2,
        OP_ADCI = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        WD_8  = 2'd0,
        WD_16 = 2'd1,
        WD_32 = 2'd2,
        WD_64 = 2'd3
    } width_e;

    localparam int FL_CF  = 0;
    localparam int FL_ECF = 1;
    localparam int FL_ZF  = 2;
    localparam int FL_EZF = 3;
    localparam int FL_PF  = 4;
    localparam int FL_AF  = 5;
    localparam int FL_SF  = 6;
    localparam int FL_OF  = 7;
    localparam int FL_N   = 8;

    typedef struct packed {
        logic of_f;
        logic sf;
        logic af;
        logic pf;
        logic ezf;
        logic zf;
        logic ecf;
        logic cf;
    } flags_t;

    function automatic logic op_uses_imm(op_e op);
        return op[0];
    endfunction

    function automatic logic op_uses_carry(op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/add_operand_sel.sv
module add_operand_sel
    import add_unit_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16,
    localparam int IDX_W = $clog2(XLEN + 1)
) (
    input  op_e               op,
    input  width_e            width,
    input  logic [XLEN-1:0]   src1,
    input  logic [XLEN-1:0]   src2,
    input  logic [IMM_W-1:0]  imm,
    input  logic              cf_now,
    output logic [XLEN-1:0]   opa,
    output logic [XLEN-1:0]   opb,
    output logic              cin,
    output logic [XLEN-1:0]   wmask,
    output logic [IDX_W-1:0]  wbits
);
    logic [XLEN-1:0] imm_ext;

    always_comb begin
        wbits   = IDX_W'(8) << width;
        wmask   = (XLEN'(1) << wbits) - XLEN'(1);
        imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        opa     = src1 & wmask;
        opb     = (op_uses_imm(op) ? imm_ext : src2) & wmask;
        cin     = op_uses_carry(op) & cf_now;
    end
endmodule

// File: rtl/add_flag_gen.sv
module add_flag_gen
    import add_unit_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int IDX_W = $clog2(XLEN + 1)
) (
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic             cin,
    input  logic [XLEN-1:0]  wmask,
    input  logic [IDX_W-1:0] wbits,
    output logic [XLEN-1:0]  res,
    output flags_t           fl
);
    logic [XLEN:0]   sum_w;
    logic [XLEN-1:0] xor3;
    logic [IDX_W-1:0] top;

    always_comb begin
        sum_w   = {1'b0, opa} + {1'b0, opb} + {{XLEN{1'b0}}, cin};
        res     = sum_w[XLEN-1:0] & wmask;
        xor3    = opa ^ opb ^ res;
        top     = wbits - IDX_W'(1);
        fl.cf   = sum_w[wbits];
        fl.ecf  = sum_w[wbits];
        fl.zf   = (res == '0);
        fl.ezf  = (res == '0);
        fl.pf   = ~^res[7:0];
        fl.af   = xor3[4];
        fl.sf   = res[top];
        fl.of_f = (opa[top] == opb[top]) && (res[top] != opa[top]);
    end
endmodule

// File: rtl/add_flag_reg.sv
module add_flag_reg
    import add_unit_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [FL_N-1:0] fmask,
    input  flags_t          fl_new,
    output logic [FL_N-1:0] fl_cur
);
    always_ff @(posedge clk) begin
        if (rst)
            fl_cur <= '0;
        else if (wr_en)
            fl_cur <= (fl_cur & ~fmask) | (fl_new & fmask);
    end

    // R10: unselected bits are preserved across a write
    assert_keep_unmasked_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((fl_cur & ~$past(fmask)) == ($past(fl_cur) & ~$past(fmask))));

    // R10: idle cycles leave the register untouched
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(fl_cur));
endmodule

// File: rtl/add_exec_unit.sv
module add_exec_unit
    import add_unit_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16,
    localparam int IDX_W = $clog2(XLEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [1:0]       in_width,
    input  logic [XLEN-1:0]  in_src1,
    input  logic [XLEN-1:0]  in_src2,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [7:0]       in_fmask,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_dest,
    output logic [7:0]       out_flags
);
    logic [XLEN-1:0]  opa, opb, wmask, res;
    logic [IDX_W-1:0] wbits;
    logic             cin;
    flags_t           fl_new;
    logic [FL_N-1:0]  fl_cur;

    add_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_sel (
        .op(op_e'(in_op)), .width(width_e'(in_width)),
        .src1(in_src1), .src2(in_src2), .imm(in_imm),
        .cf_now(fl_cur[FL_CF]),
        .opa(opa), .opb(opb), .cin(cin), .wmask(wmask), .wbits(wbits)
    );

    add_flag_gen #(.XLEN(XLEN)) u_gen (
        .opa(opa), .opb(opb), .cin(cin), .wmask(wmask), .wbits(wbits),
        .res(res), .fl(fl_new)
    );

    add_flag_reg u_freg (
        .clk(clk), .rst(rst), .wr_en(in_valid), .fmask(in_fmask),
        .fl_new(fl_new), .fl_cur(fl_cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_dest  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_dest <= res;
        end
    end

    assign out_flags = fl_cur;

    // R1: one-cycle latency from accepted operation to valid result
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drop_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4: nothing above the selected width reaches the result
    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((out_dest >> (IDX_W'(8) << $past(in_width))) == '0));

    // R6: written zero flag agrees with the registered result
    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmask[FL_ZF]) |=> (out_flags[FL_ZF] == (out_dest == '0)));

    // R5: when both carry copies are written they agree
    assert_dup_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmask[FL_CF] && in_fmask[FL_ECF]) |=>
        (out_flags[FL_CF] == out_flags[FL_ECF]));
endmodule

// File: tb/sim_add_exec_unit.sv
module sim_add_exec_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_op, in_width;
    logic [63:0] in_src1, in_src2;
    logic [15:0] in_imm;
    logic [7:0]  in_fmask;
    logic        out_valid;
    logic [63:0] out_dest;
    logic [7:0]  out_flags;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    add_exec_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_width(in_width), .in_src1(in_src1), .in_src2(in_src2),
        .in_imm(in_imm), .in_fmask(in_fmask), .out_valid(out_valid),
        .out_dest(out_dest), .out_flags(out_flags)
    );

    // {op, width, src1, src2, imm, exp_dest, exp_flags}, mask all ones
    localparam int VW = 2 + 2 + 64 + 64 + 16 + 64 + 8;
    localparam int NV = 9;
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0, 2'd0, 64'h7F, 64'h01, 16'h0, 64'h80, 8'hE0},                    // R1 R9 R8
        {2'd0, 2'd0, 64'hFF, 64'h01, 16'h0, 64'h00, 8'h3F},                    // R5 R6 R7
        {2'd2, 2'd0, 64'h10, 64'h20, 16'h0, 64'h31, 8'h00},                    // R3 with CF=1
        {2'd1, 2'd1, 64'h5, 64'h0, 16'hFFFF, 64'h4, 8'h23},                    // R2 R5 R8
        {2'd3, 2'd2, 64'h1, 64'h0, 16'h0002, 64'h4, 8'h00},                    // R3 immediate carry
        {2'd0, 2'd3, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 16'h0, 64'h0, 8'h9F}, // R9 R5
        {2'd0, 2'd2, 64'hDEAD_BEEF_0000_00FF, 64'h1234_5678_0000_0001, 16'h0, 64'h100, 8'h30}, // R4 R7
        {2'd1, 2'd3, 64'h8000, 64'h0, 16'h8000, 64'h0, 8'h1F},                 // R2 sign extension
        {2'd2, 2'd1, 64'h7FFF, 64'h0, 16'h0, 64'h8000, 8'hF0}                  // R9 overflow via carry
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [1:0] w, input logic [63:0] a,
                         input logic [63:0] b, input logic [15:0] imm, input logic [7:0] m);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_width = w;
        in_src1 = a; in_src2 = b; in_imm = imm; in_fmask = m;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_width = '0;
        in_src1 = '0; in_src2 = '0; in_imm = '0; in_fmask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 valid", {63'd0, out_valid}, 64'd0);
        check("R11 dest", out_dest, 64'd0);
        check("R11 flags", {56'd0, out_flags}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            issue(v[219:218], v[217:216], v[215:152], v[151:88], v[87:72], 8'hFF);
            check("R1 valid", {63'd0, out_valid}, 64'd1);
            check("R1-table dest R2 R3 R4", out_dest, v[71:8]);
            check("R5 R6 R7 R8 R9 flags", {56'd0, out_flags}, {56'd0, v[7:0]});
        end

        // R10: partial mask, flags were F0, op would produce 3F
        issue(2'd0, 2'd0, 64'hFF, 64'h01, 16'h0, 8'h0F);
        check("R10 partial mask", {56'd0, out_flags}, 64'hFF);

        // R10: idle cycle with inputs that would change flags
        @(negedge clk);
        in_op = 2'd0; in_width = 2'd0; in_src1 = 64'h1; in_src2 = 64'h1; in_fmask = 8'hFF;
        @(negedge clk);
        check("R10 idle flags", {56'd0, out_flags}, 64'hFF);
        check("R1 idle valid", {63'd0, out_valid}, 64'd0);
        check("R10 idle dest", out_dest, 64'h0);

        // R3 with zero mask: carry still consumed, flags untouched
        issue(2'd2, 2'd0, 64'h01, 64'h01, 16'h0, 8'h00);
        check("R3 carry-in dest", out_dest, 64'h03);
        check("R10 zero mask", {56'd0, out_flags}, 64'hFF);

        // R4: 16-bit carry out with upper junk ignored
        issue(2'd0, 2'd1, 64'hAAAA_0000_0000_FFFF, 64'h5555_0000_0000_0002, 16'h0, 8'hFF);
        check("R4 width16 dest", out_dest, 64'h0001);
        check("R5 width16 flags", {56'd0, out_flags}, 64'h23);

        // R11: reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R11 re-reset flags", {56'd0, out_flags}, 64'd0);
        check("R11 re-reset dest", out_dest, 64'd0);

        finish_run();
    end
endmodule